// File: doc/BRIEF.md
# Multiplexed Bus Machine-Cycle Generator

This block sequences one bus machine cycle for an 8-bit processor core with a 16-bit address space. In this bus scheme the low address byte and the data byte share one set of wires. The core hands the block a request: a cycle kind, an address and a byte to write. The block then steps through its T-states. It drives the upper address byte on dedicated lines. It places the low address byte on the shared bus while the address latch strobe is high. It then runs the read or write strobe and returns the captured byte together with a one-clock completion pulse.

The internal clock runs at a whole multiple of the T-state rate. This lets the latch strobe and the transfer strobes change in the middle of a T-state. A status triple tells external logic which kind of cycle is in flight. An opcode fetch adds one extra T-state after the transfer. No strobe is active in that T-state, and the fetched byte is held for the decoder.

Top module: `mcg_cycle_gen`

## Requirements
- R1: After reset, and whenever no cycle is in progress, `req_ready`=1, `ale`=0, `rd_n`=1, `wr_n`=1, `ad_oe`=0, `done`=0, `addr_hi`=0 and the status triple {io_m,s1,s0}=000; `rdata` resets to 0.
- R2: Each T-state lasts `CLKS_PER_T` clocks. An opcode fetch runs 4 T-states and every other kind runs 3. The first T-state begins on the clock after acceptance. `done` is high for exactly the one clock after the final T-state, with `req_ready` low, and `req_ready` returns high on the next clock.
- R3: In T1, `ad_out` carries address bits 7:0 with `ad_oe`=1, and `ale` is high for the first half of T1 and low for its second half. `addr_hi` carries address bits 15:8 in every T-state of the cycle. `ale` is low in all other T-states.
- R4: `req_type` encodes 0=opcode fetch, 1=memory read, 2=memory write, 3=I/O read, 4=I/O write. During every T-state {io_m,s1,s0} is 011, 010, 001, 110 or 101 respectively.
- R5: For fetch, memory read and I/O read, `rd_n` is low from the start of T2 until the middle of T3 and high otherwise, while `wr_n` stays high.
- R6: For memory write and I/O write, `wr_n` is low from the start of T2 until the middle of T3 and high otherwise, while `rd_n` stays high.
- R7: For write kinds, `ad_out` carries the request's write byte with `ad_oe`=1 through all of T2 and T3.
- R8: For read kinds (including fetch), `ad_oe` is 0 from the start of T2 to the end of the cycle.
- R9: For read kinds, the value on `ad_in` in the last clock of the first half of T3 is returned on `rdata` from the `done` clock onward. It is held until the next read-kind cycle, and write cycles leave it unchanged.
- R10: In T4 of an opcode fetch, `ale`=0, `rd_n`=1, `wr_n`=1 and `ad_oe`=0.
- R11: A request is taken only when `req_ready` is high. A `req_valid` held high while a cycle runs starts nothing until the block is idle again.
- R12: A `req_type` of 5, 6 or 7 is ignored: `req_ready` stays high and no bus activity follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, `CLKS_PER_T` periods per T-state |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_type | input | 3 | Cycle kind code |
| req_addr | input | ADDR_W | Cycle address |
| req_wdata | input | DATA_W | Byte to write |
| req_ready | output | 1 | Block idle, request may be taken |
| addr_hi | output | ADDR_W-DATA_W | Upper address lines |
| ad_out | output | DATA_W | Shared address/data bus, driven value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_in | input | DATA_W | Shared address/data bus, sampled value |
| ale | output | 1 | Address latch strobe |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| io_m | output | 1 | Status: I/O (1) or memory (0) |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| rdata | output | DATA_W | Last byte read |
| done | output | 1 | One-clock completion pulse |

## Verification
The bench builds the block with 16 address bits, 8 data bits and `CLKS_PER_T` = 2. In that setting every mid-T-state event falls on a single clock, so the latch strobe is high for exactly one clock and the read sample point is the first clock of T3. The bench derives every expected edge from its own `TB_PPT` parameter. Overriding it to 4 or 6 rebuilds the block with wider T-states and moves the half-period points away from the T-state boundaries with no change to the checks.

// File: rtl/mcg_pkg.sv
package mcg_pkg;

   typedef enum logic [2:0] {
      CT_FETCH = 3'd0,
      CT_MRD   = 3'd1,
      CT_MWR   = 3'd2,
      CT_IORD  = 3'd3,
      CT_IOWR  = 3'd4
   } cyc_t;

   typedef struct packed {
      logic io_m;
      logic s1;
      logic s0;
   } stat_t;

   localparam logic [1:0] TS_1 = 2'd0;
   localparam logic [1:0] TS_2 = 2'd1;
   localparam logic [1:0] TS_3 = 2'd2;
   localparam logic [1:0] TS_4 = 2'd3;

   function automatic logic type_legal(input logic [2:0] code);
      return code <= 3'd4;
   endfunction

   function automatic logic kind_reads(input cyc_t c);
      return (c == CT_FETCH) || (c == CT_MRD) || (c == CT_IORD);
   endfunction

   function automatic logic kind_writes(input cyc_t c);
      return (c == CT_MWR) || (c == CT_IOWR);
   endfunction

   function automatic stat_t status_of(input cyc_t c);
      stat_t s;
      case (c)
         CT_FETCH: s = '{io_m: 1'b0, s1: 1'b1, s0: 1'b1};
         CT_MRD:   s = '{io_m: 1'b0, s1: 1'b1, s0: 1'b0};
         CT_MWR:   s = '{io_m: 1'b0, s1: 1'b0, s0: 1'b1};
         CT_IORD:  s = '{io_m: 1'b1, s1: 1'b1, s0: 1'b0};
         CT_IOWR:  s = '{io_m: 1'b1, s1: 1'b0, s0: 1'b1};
         default:  s = '0;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/mcg_tseq.sv
module mcg_tseq #(
   parameter int CLKS_PER_T = 2,
   localparam int PW = (CLKS_PER_T > 1) ? $clog2(CLKS_PER_T) : 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          start,
   input  logic          is_fetch,
   output logic          active,
   output logic [1:0]    tidx,
   output logic [PW-1:0] phase,
   output logic          done
);
   import mcg_pkg::*;

   localparam logic [PW-1:0] PH_LAST = PW'(CLKS_PER_T - 1);

   logic [1:0] t_last;
   assign t_last = is_fetch ? TS_4 : TS_3;

   always_ff @(posedge clk) begin
      if (rst) begin
         active <= 1'b0;
         tidx   <= TS_1;
         phase  <= '0;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (active) begin
            if (phase == PH_LAST) begin
               phase <= '0;
               if (tidx == t_last) begin
                  active <= 1'b0;
                  tidx   <= TS_1;
                  done   <= 1'b1;
               end else begin
                  tidx <= tidx + 2'd1;
               end
            end else begin
               phase <= phase + 1'b1;
            end
         end else if (start && !done) begin
            active <= 1'b1;
            tidx   <= TS_1;
            phase  <= '0;
         end
      end
   end

endmodule

// File: rtl/mcg_strobe.sv
module mcg_strobe #(
   parameter int CLKS_PER_T = 2,
   localparam int PW = (CLKS_PER_T > 1) ? $clog2(CLKS_PER_T) : 1
) (
   input  logic            active,
   input  logic [1:0]      tidx,
   input  logic [PW-1:0]   phase,
   input  mcg_pkg::cyc_t   cyc,
   output logic            ale,
   output logic            rd_n,
   output logic            wr_n,
   output mcg_pkg::stat_t  stat,
   output logic            drv_addr,
   output logic            drv_data,
   output logic            cap_en
);
   import mcg_pkg::*;

   localparam int            MID      = CLKS_PER_T / 2;
   localparam logic [PW-1:0] PH_MID   = PW'(MID);
   localparam logic [PW-1:0] PH_PRE   = PW'(MID - 1);

   logic first_half;
   logic in_xfer;
   logic rd_kind;
   logic wr_kind;

   always_comb begin
      first_half = phase < PH_MID;
      rd_kind    = kind_reads(cyc);
      wr_kind    = kind_writes(cyc);
      in_xfer    = active && ((tidx == TS_2) || ((tidx == TS_3) && first_half));

      ale      = active && (tidx == TS_1) && first_half;
      rd_n     = !(in_xfer && rd_kind);
      wr_n     = !(in_xfer && wr_kind);
      drv_addr = active && (tidx == TS_1);
      drv_data = active && wr_kind && ((tidx == TS_2) || (tidx == TS_3));
      cap_en   = active && rd_kind && (tidx == TS_3) && (phase == PH_PRE);
      stat     = active ? status_of(cyc) : '0;
   end

endmodule

// File: rtl/mcg_busio.sv
module mcg_busio #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   localparam int HI_W  = ADDR_W - DATA_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              active,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              drv_addr,
   input  logic              drv_data,
   input  logic              cap_en,
   input  logic [DATA_W-1:0] ad_in,
   output logic [HI_W-1:0]   addr_hi,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   output logic [DATA_W-1:0] rdata
);

   for (genvar i = 0; i < DATA_W; i++) begin : g_lane
      always_comb begin
         if (drv_addr)      ad_out[i] = addr[i];
         else if (drv_data) ad_out[i] = wdata[i];
         else               ad_out[i] = 1'b0;
      end
   end

   for (genvar j = 0; j < HI_W; j++) begin : g_hi
      assign addr_hi[j] = active & addr[DATA_W + j];
   end

   assign ad_oe = drv_addr | drv_data;

   always_ff @(posedge clk) begin
      if (rst)         rdata <= '0;
      else if (cap_en) rdata <= ad_in;
   end

endmodule

// File: rtl/mcg_cycle_gen.sv
module mcg_cycle_gen #(
   parameter int ADDR_W     = 16,
   parameter int DATA_W     = 8,
   parameter int CLKS_PER_T = 2,
   localparam int HI_W      = ADDR_W - DATA_W,
   localparam int PW        = (CLKS_PER_T > 1) ? $clog2(CLKS_PER_T) : 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   input  logic [2:0]        req_type,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic [HI_W-1:0]   addr_hi,
   output logic [DATA_W-1:0] ad_out,
   output logic              ad_oe,
   input  logic [DATA_W-1:0] ad_in,
   output logic              ale,
   output logic              rd_n,
   output logic              wr_n,
   output logic              io_m,
   output logic              s1,
   output logic              s0,
   output logic [DATA_W-1:0] rdata,
   output logic              done
);
   import mcg_pkg::*;

   if (CLKS_PER_T < 2 || (CLKS_PER_T % 2) != 0) begin : g_bad_ppt
      $error("CLKS_PER_T must be even and at least 2");
   end
   if (HI_W < 1) begin : g_bad_widths
      $error("ADDR_W must exceed DATA_W");
   end

   logic              active;
   logic [1:0]        tidx;
   logic [PW-1:0]     phase;
   logic              start;
   cyc_t              cyc_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   stat_t             stat;
   logic              drv_addr;
   logic              drv_data;
   logic              cap_en;

   assign req_ready = !active && !done;
   assign start     = req_valid && req_ready && type_legal(req_type);

   always_ff @(posedge clk) begin
      if (rst) begin
         cyc_q   <= CT_FETCH;
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (start) begin
         cyc_q   <= cyc_t'(req_type);
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   mcg_tseq #(.CLKS_PER_T(CLKS_PER_T)) seq_i (
      .clk      (clk),
      .rst      (rst),
      .start    (start),
      .is_fetch (cyc_q == CT_FETCH),
      .active   (active),
      .tidx     (tidx),
      .phase    (phase),
      .done     (done)
   );

   mcg_strobe #(.CLKS_PER_T(CLKS_PER_T)) strb_i (
      .active   (active),
      .tidx     (tidx),
      .phase    (phase),
      .cyc      (cyc_q),
      .ale      (ale),
      .rd_n     (rd_n),
      .wr_n     (wr_n),
      .stat     (stat),
      .drv_addr (drv_addr),
      .drv_data (drv_data),
      .cap_en   (cap_en)
   );

   mcg_busio #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) bus_i (
      .clk      (clk),
      .rst      (rst),
      .active   (active),
      .addr     (addr_q),
      .wdata    (wdata_q),
      .drv_addr (drv_addr),
      .drv_data (drv_data),
      .cap_en   (cap_en),
      .ad_in    (ad_in),
      .addr_hi  (addr_hi),
      .ad_out   (ad_out),
      .ad_oe    (ad_oe),
      .rdata    (rdata)
   );

   assign io_m = stat.io_m;
   assign s1   = stat.s1;
   assign s0   = stat.s0;

endmodule

// File: rtl/mcg_cycle_gen_chk.sv
module mcg_cycle_gen_chk #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8
) (
   input logic       clk,
   input logic       rst,
   input logic       req_valid,
   input logic [2:0] req_type,
   input logic       req_ready,
   input logic       ad_oe,
   input logic       ale,
   input logic       rd_n,
   input logic       wr_n,
   input logic       io_m,
   input logic       s1,
   input logic       s0,
   input logic       done
);
   logic busy;
   assign busy = !req_ready && !done;

   p_strobe_excl_r5: assert property (@(posedge clk) disable iff (rst)
      !(!rd_n && !wr_n));

   p_ale_no_xfer_r3: assert property (@(posedge clk) disable iff (rst)
      ale |-> (rd_n && wr_n && ad_oe));

   p_read_release_r8: assert property (@(posedge clk) disable iff (rst)
      !rd_n |-> !ad_oe);

   p_write_drive_r7: assert property (@(posedge clk) disable iff (rst)
      !wr_n |-> ad_oe);

   p_done_pulse_r2: assert property (@(posedge clk) disable iff (rst)
      done |=> (!done && req_ready));

   p_status_hold_r4: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy)) |-> $stable({io_m, s1, s0}));

   p_accept_r11: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready && (req_type <= 3'd4)) |=> !req_ready);

   p_ignore_code_r12: assert property (@(posedge clk) disable iff (rst)
      (req_valid && req_ready && (req_type > 3'd4)) |=> req_ready);

   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (rst)
      req_ready |-> (!ale && rd_n && wr_n && !ad_oe));

endmodule

bind mcg_cycle_gen mcg_cycle_gen_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
   .clk       (clk),
   .rst       (rst),
   .req_valid (req_valid),
   .req_type  (req_type),
   .req_ready (req_ready),
   .ad_oe     (ad_oe),
   .ale       (ale),
   .rd_n      (rd_n),
   .wr_n      (wr_n),
   .io_m      (io_m),
   .s1        (s1),
   .s0        (s0),
   .done      (done)
);

// File: tb/mcg_cycle_gen_tb_top.sv
module mcg_cycle_gen_tb_top;
   parameter int TB_PPT = 2;
   localparam int MID = TB_PPT / 2;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_valid = 1'b0;
   logic [2:0]  req_type = 3'd0;
   logic [15:0] req_addr = 16'h0;
   logic [7:0]  req_wdata = 8'h0;
   logic [7:0]  ad_in = 8'h0;
   logic        req_ready, ad_oe, ale, rd_n, wr_n, io_m, s1, s0, done;
   logic [7:0]  addr_hi, ad_out, rdata;

   int checks = 0;
   int fails = 0;
   bit finished = 1'b0;
   logic [7:0] exp_rdata = 8'h00;

   always #10 clk = ~clk;

   mcg_cycle_gen #(.ADDR_W(16), .DATA_W(8), .CLKS_PER_T(TB_PPT)) dut_i (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_type(req_type),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
      .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .io_m(io_m), .s1(s1), .s0(s0),
      .rdata(rdata), .done(done)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [2:0] exp_stat(input logic [2:0] ct);
      case (ct)
         3'd0: return 3'b011;
         3'd1: return 3'b010;
         3'd2: return 3'b001;
         3'd3: return 3'b110;
         3'd4: return 3'b101;
         default: return 3'b000;
      endcase
   endfunction

   task automatic check_idle(input string tag);
      chk({"R1 ready ", tag}, req_ready, 1);
      chk({"R1 strobes ", tag}, {ale, rd_n, wr_n, ad_oe, done}, 5'b01100);
      chk({"R1 status/addr ", tag}, {io_m, s1, s0, addr_hi}, 0);
   endtask

   task automatic t_reset();
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      check_idle("after reset");
      chk("R1 rdata reset", rdata, 0);
   endtask

   task automatic run_cycle(input logic [2:0] ct, input logic [15:0] a,
                            input logic [7:0] wd, input logic [7:0] rb, input bit hold);
      int nt;
      bit is_rd;
      @(negedge clk);
      req_valid = 1'b1; req_type = ct; req_addr = a; req_wdata = wd; ad_in = ~rb;
      nt = (ct == 3'd0) ? 4 : 3;
      is_rd = (ct == 3'd0) || (ct == 3'd1) || (ct == 3'd3);
      for (int k = 0; k < nt * TB_PPT; k++) begin
         int t;
         int ph;
         bit xfer;
         @(negedge clk);
         if (!hold) req_valid = 1'b0;
         else begin req_type = (ct == 3'd0) ? 3'd1 : 3'd0; req_addr = ~a; end
         t = k / TB_PPT;
         ph = k % TB_PPT;
         xfer = (t == 1) || (t == 2 && ph < MID);
         chk("R11 busy ready", req_ready, 0);
         chk("R3 addr_hi", addr_hi, a[15:8]);
         chk("R4 status", {io_m, s1, s0}, exp_stat(ct));
         if (t == 0) begin
            chk("R3 ale", ale, (ph < MID) ? 1 : 0);
            chk("R3 low addr", {ad_oe, ad_out}, {1'b1, a[7:0]});
            chk("R3 no strobe", {rd_n, wr_n}, 2'b11);
         end else if (t == 3) begin
            chk("R10 decode state", {ale, rd_n, wr_n, ad_oe}, 4'b0110);
         end else begin
            chk("R3 ale low", ale, 0);
            if (is_rd) begin
               chk("R5 rd_n", rd_n, xfer ? 0 : 1);
               chk("R5 wr_n", wr_n, 1);
               chk("R8 released", ad_oe, 0);
            end else begin
               chk("R6 wr_n", wr_n, xfer ? 0 : 1);
               chk("R6 rd_n", rd_n, 1);
               chk("R7 write data", {ad_oe, ad_out}, {1'b1, wd});
            end
         end
         ad_in = (t == 2 && ph == MID - 1) ? rb : ~rb;
      end
      @(negedge clk);
      req_valid = 1'b0;
      if (is_rd) exp_rdata = rb;
      chk("R2 done pulse", {done, req_ready}, 2'b10);
      chk("R9 rdata", rdata, exp_rdata);
      @(negedge clk);
      chk("R2 done cleared", {done, req_ready}, 2'b01);
      chk("R9 rdata held", rdata, exp_rdata);
      check_idle("after cycle R11");
   endtask

   task automatic t_illegal(input logic [2:0] code);
      @(negedge clk);
      req_valid = 1'b1; req_type = code; req_addr = 16'hFFFF;
      @(negedge clk);
      chk("R12 ignored ready", req_ready, 1);
      chk("R12 no activity", {ale, rd_n, wr_n, ad_oe, io_m, s1, s0}, 7'b0110000);
      @(negedge clk);
      req_valid = 1'b0;
      chk("R12 still idle", {req_ready, ale, ad_oe}, 3'b100);
   endtask

   initial begin
      t_reset();
      run_cycle(3'd0, 16'h4125, 8'h00, 8'hDB, 1'b0);  // fetch
      run_cycle(3'd1, 16'h4126, 8'h00, 8'hC0, 1'b0);  // memory read
      run_cycle(3'd2, 16'h526A, 8'h3C, 8'h77, 1'b0);  // memory write, R9 unchanged
      run_cycle(3'd3, 16'hC0C0, 8'h00, 8'h5E, 1'b0);  // I/O read
      run_cycle(3'd4, 16'h0101, 8'hA5, 8'h11, 1'b0);  // I/O write
      run_cycle(3'd0, 16'hFF00, 8'h00, 8'h00, 1'b1);  // held request, R11
      run_cycle(3'd2, 16'h00FF, 8'hFF, 8'h99, 1'b1);
      t_illegal(3'd5);
      t_illegal(3'd7);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL R2 watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule